// File: doc/BRIEF.md
# Masked Program-Memory Checksum Engine

This block computes the 16-bit verification checksum of a 512-word program memory with 12-bit words. After a start pulse it walks the memory through a synchronous read port, one address per cycle, and adds every returned word into a 16-bit accumulator that drops any carry. The accumulator starts from the configuration word ANDed with 0x01F. When the configuration word selects code protection, the start value also includes a 16-bit value packed from the low nibbles of the four user ID words.

The protection mode decides how much memory is summed. In open mode the engine reads words 0x000 through 0x1FE. In protected mode it reads only words 0x000 through 0x03F. When the last word has been added, the engine pulses `done` and leaves the result on `checksum` until the next accepted start.

Top module: `prog_checksum_engine`

## Requirements
- R1: While reset is held, and in the first cycle after it, `busy`, `done` and `mem_rd_en` are 0 and `checksum` is 0.
- R2: When `cfg_word` bit 3 is 1 at start (open mode), the result is the sum of words 0x000..0x1FE plus (`cfg_word` & 0x01F).
- R3: When `cfg_word` bit 3 is 0 at start (protected mode), the result is the sum of words 0x000..0x03F, plus (`cfg_word` & 0x01F), plus the packed ID value.
- R4: The packed ID value takes bits [3:0] of each ID word, and ignores the upper 8 bits. `id_words[11:0]` is ID0 and supplies bits [15:12]. `id_words[23:12]` is ID1, then ID2, and `id_words[47:36]` is ID3, which supplies bits [3:0]. IDs 0xFF1, 0xFF2, 0xFF3 and 0xFF4 give 0x1234.
- R5: The sum is modulo 2^16. A blank memory (all 0xFFF) with configuration word 0xFFF gives 0xEE20. The same memory with configuration word 0xFF7 and IDs holding nibbles E, E, 2, 0 gives 0xEDF7.
- R6: Reads are issued on consecutive cycles at ascending addresses, starting at 0 and ending at the mode's last address. Address 0x1FF is never read.
- R7: `mem_rdata` is the word at the address of the previous cycle's read. `done` is a one-cycle pulse that becomes visible N+1 clock edges after the start edge, where N is the number of words summed. `busy` is high from the start edge until that edge.
- R8: After `done`, `checksum` keeps its value until the next accepted start.
- R9: A `start` pulse while `busy` is high has no effect on the reads, on the timing of `done`, or on the result.
- R10: The mode, the configuration word and the ID words are sampled on the start edge. Changes to them during a run do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start request, accepted when not busy |
| cfg_word | input | 12 | Configuration word (bit 3 = 0 selects protected mode) |
| id_words | input | 48 | Four user ID words, ID0 in bits [11:0] |
| mem_rd_en | output | 1 | Read strobe to the program memory |
| mem_addr | output | 9 | Read address |
| mem_rdata | input | 12 | Read data, one cycle after the strobe |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| checksum | output | 16 | Checksum result |

## Verification
The result is due a fixed number of edges after the start edge. That is 512 edges in open mode (511 words plus one cycle of read latency) and 65 in protected mode. Each scenario counts falling edges from the start edge and requires `done` on exactly that count. The checksum is read at that same sample and again 20 cycles later. A monitor on the read strobe confirms the address order and the read count for each run. Both the mid-run restart test and the mid-run input-change test check that the due cycle and the result are unchanged.

// File: rtl/ckm_pkg.sv
package ckm_pkg;

    // Geometry of the memory being summed
    localparam int WORD_W = 12;
    localparam int ADDR_W = 9;
    localparam int SUM_W  = 16;
    localparam int ID_NUM = 4;
    localparam int NIB_W  = 4;
    localparam int CP_BIT = 3;

    // Last address summed in each mode
    localparam logic [ADDR_W-1:0] LAST_OPEN   = 9'h1FE;
    localparam logic [ADDR_W-1:0] LAST_LOCKED = 9'h03F;

    // Configuration bits that enter the sum
    localparam logic [WORD_W-1:0] CFG_KEEP = 12'h01F;

    typedef logic [SUM_W-1:0] sum_t;

    typedef enum logic [0:0] {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    // One read beat travelling through the read latency stage
    typedef struct packed {
        logic vld;
        logic last;
    } beat_t;

    // Zero-extend a memory word to the accumulator width
    function automatic sum_t widen(input logic [WORD_W-1:0] w);
        return {{(SUM_W-WORD_W){1'b0}}, w};
    endfunction

    // Protection is active when the selected configuration bit is cleared
    function automatic logic is_locked(input logic [WORD_W-1:0] cfg);
        return ~cfg[CP_BIT];
    endfunction

endpackage

// File: rtl/ckm_seed.sv
module ckm_seed
    import ckm_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_ID_NUM = ID_NUM,
    parameter int P_NIB_W  = NIB_W,
    parameter int P_SUM_W  = SUM_W
) (
    input  logic [P_WORD_W-1:0]          cfg,
    input  logic [P_ID_NUM*P_WORD_W-1:0] ids,
    output logic                         locked,
    output logic [P_SUM_W-1:0]           seed
);
    localparam int PACK_W = P_ID_NUM * P_NIB_W;
    localparam logic [PACK_W-1:0] NIB_MASK = PACK_W'((1 << P_NIB_W) - 1);

    logic [PACK_W-1:0]  id_pack;
    logic [P_SUM_W-1:0] cfg_part;
    logic [P_SUM_W-1:0] id_part;

    // ID0 lands in the most significant nibble
    always_comb begin
        id_pack = '0;
        for (int g = 0; g < P_ID_NUM; g++) begin
            id_pack = id_pack
                    | ((PACK_W'(ids >> (g * P_WORD_W)) & NIB_MASK)
                       << ((P_ID_NUM - 1 - g) * P_NIB_W));
        end
    end

    assign locked   = is_locked(cfg);
    assign cfg_part = P_SUM_W'(cfg & CFG_KEEP);
    assign id_part  = locked ? P_SUM_W'(id_pack) : '0;
    assign seed     = cfg_part + id_part;

endmodule

// File: rtl/ckm_seq.sv
module ckm_seq
    import ckm_pkg::*;
#(
    parameter int                P_ADDR_W      = ADDR_W,
    parameter logic [P_ADDR_W-1:0] P_LAST_OPEN   = LAST_OPEN,
    parameter logic [P_ADDR_W-1:0] P_LAST_LOCKED = LAST_LOCKED
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic                locked,
    output logic                rd_en,
    output logic [P_ADDR_W-1:0] rd_addr,
    output logic                rd_last
);
    seq_state_e          state_q;
    logic [P_ADDR_W-1:0] addr_q;
    logic [P_ADDR_W-1:0] limit_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEQ_IDLE;
            addr_q  <= '0;
            limit_q <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (go) begin
                        state_q <= SEQ_RUN;
                        addr_q  <= '0;
                        limit_q <= locked ? P_LAST_LOCKED : P_LAST_OPEN;
                    end
                end
                SEQ_RUN: begin
                    if (addr_q == limit_q) begin
                        state_q <= SEQ_IDLE;
                    end else begin
                        addr_q <= addr_q + 1'b1;
                    end
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

    assign rd_en   = (state_q == SEQ_RUN);
    assign rd_addr = addr_q;
    assign rd_last = rd_en && (addr_q == limit_q);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && $past(rd_en)) |-> (rd_addr == $past(rd_addr) + 1'b1));

    // R6
    addr_bound_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |-> (rd_addr <= P_LAST_OPEN));

    // R6
    addr_first_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(rd_en) |-> (rd_addr == '0));

endmodule

// File: rtl/ckm_acc.sv
module ckm_acc
    import ckm_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_SUM_W  = SUM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                go,
    input  logic [P_SUM_W-1:0]  seed,
    input  logic                rd_en,
    input  logic                rd_last,
    input  logic [P_WORD_W-1:0] rdata,
    output logic [P_SUM_W-1:0]  sum,
    output logic                done,
    output logic                pend
);
    beat_t              beat_q;
    logic [P_SUM_W-1:0] acc_q;
    logic               done_q;

    // The read beat is delayed by one stage to meet the returning data
    always_ff @(posedge clk) begin
        if (rst) begin
            beat_q <= '0;
        end else begin
            beat_q.vld  <= rd_en;
            beat_q.last <= rd_last;
        end
    end

    // Carries out of the top bit are dropped by the fixed width
    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= beat_q.vld && beat_q.last;
            if (go) begin
                acc_q <= seed;
            end else if (beat_q.vld) begin
                acc_q <= acc_q + P_SUM_W'(rdata);
            end
        end
    end

    assign sum  = acc_q;
    assign done = done_q;
    assign pend = beat_q.vld;

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        (!pend && !go) |=> $stable(sum));

endmodule

// File: rtl/prog_checksum_engine.sv
module prog_checksum_engine
    import ckm_pkg::*;
#(
    parameter int P_WORD_W = WORD_W,
    parameter int P_ADDR_W = ADDR_W,
    parameter int P_SUM_W  = SUM_W,
    parameter int P_ID_NUM = ID_NUM
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [P_WORD_W-1:0]          cfg_word,
    input  logic [P_ID_NUM*P_WORD_W-1:0] id_words,
    output logic                         mem_rd_en,
    output logic [P_ADDR_W-1:0]          mem_addr,
    input  logic [P_WORD_W-1:0]          mem_rdata,
    output logic                         busy,
    output logic                         done,
    output logic [P_SUM_W-1:0]           checksum
);
    logic               go;
    logic               locked;
    logic [P_SUM_W-1:0] seed;
    logic               rd_last;
    logic               pend;

    // A start is taken only when no read or pending beat is in flight
    assign busy = mem_rd_en | pend;
    assign go   = start & ~busy;

    ckm_seed #(
        .P_WORD_W (P_WORD_W),
        .P_ID_NUM (P_ID_NUM),
        .P_NIB_W  (NIB_W),
        .P_SUM_W  (P_SUM_W)
    ) seed_i (
        .cfg    (cfg_word),
        .ids    (id_words),
        .locked (locked),
        .seed   (seed)
    );

    ckm_seq #(
        .P_ADDR_W      (P_ADDR_W),
        .P_LAST_OPEN   (P_ADDR_W'(LAST_OPEN)),
        .P_LAST_LOCKED (P_ADDR_W'(LAST_LOCKED))
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .locked  (locked),
        .rd_en   (mem_rd_en),
        .rd_addr (mem_addr),
        .rd_last (rd_last)
    );

    ckm_acc #(
        .P_WORD_W (P_WORD_W),
        .P_SUM_W  (P_SUM_W)
    ) acc_i (
        .clk     (clk),
        .rst     (rst),
        .go      (go),
        .seed    (seed),
        .rd_en   (mem_rd_en),
        .rd_last (rd_last),
        .rdata   (mem_rdata),
        .sum     (checksum),
        .done    (done),
        .pend    (pend)
    );

    // R7
    busy_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    // R9
    no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (start && mem_rd_en && !rd_last) |=> (mem_rd_en && mem_addr != '0));

endmodule

// File: tb/prog_checksum_engine_tb_top.sv
module prog_checksum_engine_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [11:0] cfg_word = 12'hFFF;
    logic [47:0] id_words = '0;
    logic        mem_rd_en;
    logic [8:0]  mem_addr;
    logic [11:0] mem_rdata;
    logic        busy;
    logic        done;
    logic [15:0] checksum;

    int errors = 0;
    int checks = 0;

    logic [11:0] mem [512];

    // Read-order monitor state
    int          rd_count;
    int          rd_bad;
    int          rd_max;
    logic [9:0]  rd_next;

    always #5 clk = ~clk;

    prog_checksum_engine dut_i (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .cfg_word  (cfg_word),
        .id_words  (id_words),
        .mem_rd_en (mem_rd_en),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .busy      (busy),
        .done      (done),
        .checksum  (checksum)
    );

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    always @(posedge clk) begin
        if (mem_rd_en) begin
            if ({1'b0, mem_addr} != rd_next) rd_bad++;
            if (int'(mem_addr) > rd_max) rd_max = int'(mem_addr);
            rd_next = {1'b0, mem_addr} + 10'd1;
            rd_count++;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] model(input logic [11:0] cfg, input logic [47:0] ids);
        logic [15:0] s;
        int last;
        last = cfg[3] ? 'h1FE : 'h03F;
        s = {11'd0, cfg[4:0]};
        for (int a = 0; a <= last; a++) s = s + {4'd0, mem[a]};
        if (!cfg[3]) s = s + {ids[3:0], ids[15:12], ids[27:24], ids[39:36]};
        return s;
    endfunction

    function automatic logic [47:0] pack_ids(input logic [11:0] i0, input logic [11:0] i1,
                                             input logic [11:0] i2, input logic [11:0] i3);
        return {i3, i2, i1, i0};
    endfunction

    // Runs one checksum; optional mid-run restart or input change at cycle 10
    task automatic run(input string tag, input logic [11:0] cfg, input logic [47:0] ids,
                       input logic [15:0] exp, input int disturb);
        int words;
        int k;
        logic [15:0] res;
        words = cfg[3] ? 511 : 64;
        rd_count = 0; rd_bad = 0; rd_max = 0; rd_next = '0;
        @(negedge clk);
        cfg_word = cfg; id_words = ids; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        k = 0;
        while (k < 2000) begin
            @(negedge clk);
            k++;
            start = 1'b0;
            if (disturb == 1 && k == 10) start = 1'b1;
            if (disturb == 2 && k == 10) begin
                cfg_word = cfg ^ 12'h01F;
                id_words = ~ids;
            end
            if (done) break;
        end
        start = 1'b0;
        res = checksum;
        chk({tag, " R7 done cycle"}, k, words + 1);
        chk({tag, " R2/R3 sum"}, res, exp);
        chk({tag, " R6 read count"}, rd_count, words);
        chk({tag, " R6 read order"}, rd_bad, 0);
        chk({tag, " R6 max addr"}, rd_max, words - 1);
        @(negedge clk);
        chk({tag, " R7 done pulse width"}, done, 0);
        chk({tag, " R7 busy low"}, busy, 0);
        repeat (20) @(negedge clk);
        chk({tag, " R8 result held"}, checksum, res);
    endtask

    task automatic fill(input int kind);
        for (int a = 0; a < 512; a++) begin
            case (kind)
                0: mem[a] = 12'hFFF;
                1: mem[a] = 12'h000;
                default: mem[a] = 12'((a * 37 + 5) ^ (a << 3));
            endcase
        end
    endtask

    task automatic t_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        chk("R1 busy in reset", busy, 0);
        chk("R1 done in reset", done, 0);
        chk("R1 rd_en in reset", mem_rd_en, 0);
        chk("R1 sum in reset", checksum, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 busy after reset", busy, 0);
        chk("R1 sum after reset", checksum, 0);
    endtask

    task automatic t_blank();
        fill(0);
        // R5 open blank, carry dropped
        run("R5 blank open", 12'hFFF, pack_ids(12'hFFF, 12'hFFF, 12'hFFF, 12'hFFF), 16'hEE20, 0);
        // R5 R3 protected blank
        run("R5 blank locked", 12'hFF7, pack_ids(12'hFFE, 12'hFFE, 12'hFF2, 12'hFF0), 16'hEDF7, 0);
    endtask

    task automatic t_id_pack();
        fill(1);
        // R4 nibble order, upper bits ignored
        run("R4 id pack", 12'h000, pack_ids(12'hFF1, 12'hFF2, 12'hFF3, 12'hFF4), 16'h1234, 0);
    endtask

    task automatic t_pattern();
        logic [11:0] c;
        logic [47:0] ids;
        fill(2);
        mem[9'h1FF] = 12'hABC;
        ids = pack_ids(12'h5A7, 12'h0C3, 12'h9E1, 12'h33F);
        c = 12'hA3D;
        run("R2 pattern open", c, ids, model(c, ids), 0);
        c = 12'h5F2;
        run("R3 pattern locked", c, ids, model(c, ids), 0);
        c = 12'h018;
        run("R2 pattern open low cfg", c, ids, model(c, ids), 0);
    endtask

    task automatic t_restart();
        logic [11:0] c;
        logic [47:0] ids;
        ids = pack_ids(12'h123, 12'h456, 12'h789, 12'hABC);
        c = 12'h0F4;
        run("R9 restart locked", c, ids, model(c, ids), 1);
        c = 12'hFFE;
        run("R9 restart open", c, ids, model(c, ids), 1);
    endtask

    task automatic t_sample();
        logic [11:0] c;
        logic [47:0] ids;
        ids = pack_ids(12'h00A, 12'h00B, 12'h00C, 12'h00D);
        c = 12'h3E7;
        run("R10 inputs change locked", c, ids, model(c, ids), 2);
        c = 12'h80C;
        run("R10 inputs change open", c, ids, model(c, ids), 2);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        t_reset();
        t_blank();
        t_id_pack();
        t_pattern();
        t_restart();
        t_sample();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule